// File: doc/BRIEF.md
# Host-to-Processor Double-Buffered Mailbox

This block carries data words in both directions between an 8-bit external host port and a 24-bit processor register interface. Each direction has two buffer stages. The first stage is a source register that one side fills. The second stage is a destination register that the other side drains. Every stage owns one flag: an empty flag on each source register and a full flag on each destination register. When a source holds a word and its destination has room, the word moves across by itself on the next clock edge.

On the host side, three byte lanes (high, middle, low) are addressed with a select code. The low byte is always handled last. Writing the low byte commits a host word. Reading the low byte releases a received word. The processor writes and reads whole 24-bit words. It also owns a small control register that holds two interrupt enables, a command enable bit and two general host flag bits. Interrupt requests combine the processor-side flags with these enables.

There are four reset inputs: hardware, software, individual (peripheral disable) and stop. All four return the handshake flags to their idle state. Only hardware and software reset clear the control register. No reset touches the data registers.

Top module: `host_mbox`

## Requirements
- R1: While or just after hardware reset is asserted, cpu_tx_empty and host_tx_empty read 1, cpu_rx_full and host_rx_full read 0, both interrupt requests are 0 and cpu_ctl_rdata reads 0.
- R2: A processor write (cpu_tx_we) clears cpu_tx_empty at that clock edge and loads all 24 bits of cpu_tx_wdata.
- R3: On the edge after cpu_tx_empty and host_rx_full are both 0, the transmit word moves to the host receive bytes, host_rx_full becomes 1 and cpu_tx_empty becomes 1. With host_sel = 2, 1 or 0, host_rdata shows bits 23:16, 15:8 or 7:0 respectively.
- R4: A host read (host_re) with host_sel = 0 clears host_rx_full. Reads with host_sel = 2 or 1 leave it unchanged.
- R5: Host writes with host_sel = 2, 1, 0 load bits 23:16, 15:8 and 7:0 of the host transmit word. Only the write with host_sel = 0 clears host_tx_empty. On the edge after host_tx_empty and cpu_rx_full are both 0, the word appears on cpu_rx_rdata, cpu_rx_full becomes 1 and host_tx_empty becomes 1.
- R6: A processor read (cpu_rx_re) clears cpu_rx_full at that edge.
- R7: While a destination is full, its contents stay unchanged and the waiting source word keeps its empty flag at 0. The word moves on the edge after the destination is released.
- R8: irq_rx is 1 exactly when cpu_rx_full is 1 and control bit 0 is 1. irq_tx is 1 exactly when cpu_tx_empty is 1 and control bit 1 is 1.
- R9: None of the four resets changes the word shown on cpu_rx_rdata or the bytes shown on host_rdata.
- R10: The control register (bit 0 receive enable, bit 1 transmit enable, bit 2 command enable, bits 4:3 host flags) clears on hardware and software reset and keeps its value on individual and stop reset. All four resets return the handshake flags to empty = 1, full = 0.
- R11: If a processor write lands on the same edge as a processor-to-host move, the move carries the old word and cpu_tx_empty stays 0 for the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset |
| ind_rst | input | 1 | Individual (peripheral disable) reset |
| stop_rst | input | 1 | Stop reset |
| cpu_tx_we | input | 1 | Processor write strobe for the transmit word |
| cpu_tx_wdata | input | 24 | Processor transmit word |
| cpu_rx_re | input | 1 | Processor read strobe for the receive word |
| cpu_rx_rdata | output | 24 | Processor receive word |
| cpu_ctl_we | input | 1 | Control register write strobe |
| cpu_ctl_wdata | input | 5 | Control register write value |
| cpu_ctl_rdata | output | 5 | Control register contents |
| cpu_rx_full | output | 1 | Processor receive word is valid |
| cpu_tx_empty | output | 1 | Processor transmit register may be written |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| host_sel | input | 2 | Host byte select: 2 high, 1 middle, 0 low |
| host_we | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_re | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Selected host receive byte |
| host_rx_full | output | 1 | Host receive bytes are valid |
| host_tx_empty | output | 1 | Host transmit bytes may be written |

## Verification
Any flag that sticks shows at the ports within one or two edges. A move that fails to happen, or happens early, leaves host_rx_full or cpu_rx_full disagreeing with the expected value on the edge after both enabling flags clear. A byte lane that is swapped or missing corrupts host_rdata or cpu_rx_rdata for the whole word. The bench therefore sweeps many word patterns through both directions and checks the flags on every edge. A reset that touches data, or that clears control on the wrong reset type, appears on the read ports on the very next cycle after that reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 3;
    localparam int WORD_W  = BYTE_W * NBYTES;
    localparam int LOW_SEL = 0;

    // Control register layout: rx_ie is bit 0, hflag occupies bits 4:3
    typedef struct packed {
        logic [1:0] hflag;
        logic       cmd_ie;
        logic       tx_ie;
        logic       rx_ie;
    } ctl_t;

    typedef struct packed {
        logic hw;
        logic sw;
        logic ind;
        logic stop;
    } rst_t;

    function automatic logic flags_reset(rst_t r);
        return r.hw | r.sw | r.ind | r.stop;
    endfunction

    function automatic logic ctl_reset(rst_t r);
        return r.hw | r.sw;
    endfunction

endpackage

// File: rtl/mbox_lane.sv
module mbox_lane #(
    parameter int BYTE_W = mbox_pkg::BYTE_W,
    parameter int NBYTES = mbox_pkg::NBYTES,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              flag_rst,
    input  logic [NBYTES-1:0] src_be,
    input  logic [WORD_W-1:0] src_wdata,
    input  logic              src_commit,
    input  logic              dst_take,
    output logic [WORD_W-1:0] dst_data,
    output logic              src_empty,
    output logic              dst_full
);

    logic [WORD_W-1:0] src_data;
    logic              move;

    assign move = !src_empty && !dst_full && !flag_rst;

    // Source stage: each byte lane loads on its own enable, never reset
    for (genvar b = 0; b < NBYTES; b++) begin : g_src_byte
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (src_be[b])
                byte_q <= src_wdata[b*BYTE_W +: BYTE_W];
        end
        assign src_data[b*BYTE_W +: BYTE_W] = byte_q;
    end

    // Destination stage: loaded only by a move, never reset
    always_ff @(posedge clk) begin
        if (move)
            dst_data <= src_data;
    end

    // Handshake flags: the side's own access wins over the move
    always_ff @(posedge clk) begin
        if (flag_rst) begin
            src_empty <= 1'b1;
            dst_full  <= 1'b0;
        end else begin
            if (src_commit)
                src_empty <= 1'b0;
            else if (move)
                src_empty <= 1'b1;
            if (dst_take)
                dst_full <= 1'b0;
            else if (move)
                dst_full <= 1'b1;
        end
    end

    AST_RST_IDLE_FLAGS: assert property (@(posedge clk)
        flag_rst |=> (src_empty && !dst_full)) else $error("flags not idle after reset"); // R1

    AST_COMMIT_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (flag_rst)
        src_commit |=> !src_empty) else $error("commit did not clear empty"); // R2

    AST_MOVE_FILLS_DST: assert property (@(posedge clk) disable iff (flag_rst)
        (!src_empty && !dst_full && !dst_take) |=> dst_full) else $error("move did not set full"); // R3

    AST_TAKE_CLEARS_FULL: assert property (@(posedge clk) disable iff (flag_rst)
        dst_take |=> !dst_full) else $error("take did not clear full"); // R6

    AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (flag_rst)
        dst_full |=> $stable(dst_data)) else $error("full destination changed"); // R7

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic clk,
    input  rst_t rsts,
    input  logic ctl_we,
    input  ctl_t ctl_wdata,
    output ctl_t ctl_q
);

    always_ff @(posedge clk) begin
        if (ctl_reset(rsts))
            ctl_q <= '0;
        else if (ctl_we)
            ctl_q <= ctl_wdata;
    end

    AST_CTL_CLEARS: assert property (@(posedge clk)
        (rsts.hw || rsts.sw) |=> (ctl_q == '0)) else $error("control not cleared"); // R10

    AST_CTL_LOADS: assert property (@(posedge clk) disable iff (rsts.hw || rsts.sw)
        ctl_we |=> (ctl_q == $past(ctl_wdata))) else $error("control write lost"); // R10

endmodule

// File: rtl/host_mbox.sv
module host_mbox #(
    parameter int BYTE_W = mbox_pkg::BYTE_W,
    parameter int NBYTES = mbox_pkg::NBYTES,
    localparam int WORD_W = BYTE_W * NBYTES,
    localparam int SEL_W  = $clog2(NBYTES),
    localparam int CTL_W  = $bits(mbox_pkg::ctl_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              ind_rst,
    input  logic              stop_rst,
    input  logic              cpu_tx_we,
    input  logic [WORD_W-1:0] cpu_tx_wdata,
    input  logic              cpu_rx_re,
    output logic [WORD_W-1:0] cpu_rx_rdata,
    input  logic              cpu_ctl_we,
    input  logic [CTL_W-1:0]  cpu_ctl_wdata,
    output logic [CTL_W-1:0]  cpu_ctl_rdata,
    output logic              cpu_rx_full,
    output logic              cpu_tx_empty,
    output logic              irq_rx,
    output logic              irq_tx,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_re,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_rx_full,
    output logic              host_tx_empty
);
    import mbox_pkg::*;

    rst_t              rsts;
    logic              flag_rst;
    ctl_t              ctl;
    logic [NBYTES-1:0] host_be;
    logic [WORD_W-1:0] host_rx_word;
    logic              host_low;

    assign rsts     = '{hw: rst, sw: sw_rst, ind: ind_rst, stop: stop_rst};
    assign flag_rst = flags_reset(rsts);
    assign host_low = (host_sel == SEL_W'(LOW_SEL));

    for (genvar b = 0; b < NBYTES; b++) begin : g_host_be
        assign host_be[b] = host_we && (host_sel == SEL_W'(b));
    end

    // Processor to host direction
    mbox_lane #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_to_host (
        .clk       (clk),
        .flag_rst  (flag_rst),
        .src_be    ({NBYTES{cpu_tx_we}}),
        .src_wdata (cpu_tx_wdata),
        .src_commit(cpu_tx_we),
        .dst_take  (host_re && host_low),
        .dst_data  (host_rx_word),
        .src_empty (cpu_tx_empty),
        .dst_full  (host_rx_full)
    );

    // Host to processor direction
    mbox_lane #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_to_cpu (
        .clk       (clk),
        .flag_rst  (flag_rst),
        .src_be    (host_be),
        .src_wdata ({NBYTES{host_wdata}}),
        .src_commit(host_we && host_low),
        .dst_take  (cpu_rx_re),
        .dst_data  (cpu_rx_rdata),
        .src_empty (host_tx_empty),
        .dst_full  (cpu_rx_full)
    );

    mbox_ctrl u_ctrl (
        .clk      (clk),
        .rsts     (rsts),
        .ctl_we   (cpu_ctl_we),
        .ctl_wdata(ctl_t'(cpu_ctl_wdata)),
        .ctl_q    (ctl)
    );

    assign cpu_ctl_rdata = ctl;
    assign irq_rx        = cpu_rx_full  && ctl.rx_ie;
    assign irq_tx        = cpu_tx_empty && ctl.tx_ie;

    always_comb begin
        host_rdata = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (host_sel == SEL_W'(b))
                host_rdata = host_rx_word[b*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: tb/host_mbox_bench.sv
`timescale 1ns/1ps
module host_mbox_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b0, sw_rst = 1'b0, ind_rst = 1'b0, stop_rst = 1'b0;
    logic        cpu_tx_we = 1'b0, cpu_rx_re = 1'b0, cpu_ctl_we = 1'b0;
    logic [23:0] cpu_tx_wdata = '0;
    logic [23:0] cpu_rx_rdata;
    logic [4:0]  cpu_ctl_wdata = '0;
    logic [4:0]  cpu_ctl_rdata;
    logic        cpu_rx_full, cpu_tx_empty, irq_rx, irq_tx;
    logic [1:0]  host_sel = '0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rx_full, host_tx_empty;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    host_mbox u_host_mbox (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .ind_rst(ind_rst), .stop_rst(stop_rst),
        .cpu_tx_we(cpu_tx_we), .cpu_tx_wdata(cpu_tx_wdata),
        .cpu_rx_re(cpu_rx_re), .cpu_rx_rdata(cpu_rx_rdata),
        .cpu_ctl_we(cpu_ctl_we), .cpu_ctl_wdata(cpu_ctl_wdata), .cpu_ctl_rdata(cpu_ctl_rdata),
        .cpu_rx_full(cpu_rx_full), .cpu_tx_empty(cpu_tx_empty),
        .irq_rx(irq_rx), .irq_tx(irq_tx),
        .host_sel(host_sel), .host_we(host_we), .host_wdata(host_wdata),
        .host_re(host_re), .host_rdata(host_rdata),
        .host_rx_full(host_rx_full), .host_tx_empty(host_tx_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [23:0] pat(input int k);
        return 24'((k * 32'h000B1D35) ^ (k << 19) ^ 32'h005A00C3);
    endfunction

    function automatic logic [7:0] byte_of(input logic [23:0] w, input int b);
        return 8'((w >> (8 * b)) & 24'hFF);
    endfunction

    task automatic cpu_send(input logic [23:0] w);
        cpu_tx_we = 1'b1; cpu_tx_wdata = w;
        tick();
        cpu_tx_we = 1'b0;
    endtask

    task automatic host_take_low();
        host_sel = 2'd0; host_re = 1'b1;
        tick();
        host_re = 1'b0;
    endtask

    task automatic host_send(input logic [23:0] w);
        for (int b = 2; b >= 0; b--) begin
            host_sel = 2'(b); host_we = 1'b1; host_wdata = byte_of(w, b);
            tick();
        end
        host_we = 1'b0;
    endtask

    task automatic host_bytes(input string tag, input logic [23:0] w);
        for (int b = 2; b >= 0; b--) begin
            host_sel = 2'(b);
            #0.5;
            chk(tag, {24'd0, host_rdata}, {24'd0, byte_of(w, b)});
        end
    endtask

    task automatic pulse_ctl(input logic [4:0] v);
        cpu_ctl_we = 1'b1; cpu_ctl_wdata = v;
        tick();
        cpu_ctl_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] wa, wb;
        rst = 1'b1;
        tick(); tick();
        // R1: idle state under hardware reset
        chk("R1 cpu_tx_empty", cpu_tx_empty, 1);
        chk("R1 host_tx_empty", host_tx_empty, 1);
        chk("R1 cpu_rx_full", cpu_rx_full, 0);
        chk("R1 host_rx_full", host_rx_full, 0);
        chk("R1 irqs", {irq_rx, irq_tx}, 0);
        chk("R1 ctl", cpu_ctl_rdata, 0);
        rst = 1'b0;
        tick();

        // Processor to host sweep (R2, R3, R4)
        for (int k = 0; k < 24; k++) begin
            cpu_send(pat(k));
            chk("R2 tx_empty cleared", cpu_tx_empty, 0);
            chk("R3 not early", host_rx_full, 0);
            tick();
            chk("R3 host_rx_full", host_rx_full, 1);
            chk("R3 tx_empty set", cpu_tx_empty, 1);
            host_bytes("R3 bytes", pat(k));
            host_sel = 2'd2; host_re = 1'b1; tick();
            host_sel = 2'd1; tick(); host_re = 1'b0;
            chk("R4 high/mid reads keep full", host_rx_full, 1);
            host_take_low();
            chk("R4 low read clears full", host_rx_full, 0);
        end

        // Host to processor sweep (R5, R6)
        for (int k = 0; k < 24; k++) begin
            wa = pat(k + 100);
            host_sel = 2'd2; host_we = 1'b1; host_wdata = byte_of(wa, 2); tick();
            host_sel = 2'd1; host_wdata = byte_of(wa, 1); tick();
            chk("R5 upper writes keep empty", host_tx_empty, 1);
            host_sel = 2'd0; host_wdata = byte_of(wa, 0); tick();
            host_we = 1'b0;
            chk("R5 low write clears empty", host_tx_empty, 0);
            tick();
            chk("R5 cpu_rx_full", cpu_rx_full, 1);
            chk("R5 host_tx_empty set", host_tx_empty, 1);
            chk("R5 word", cpu_rx_rdata, wa);
            cpu_rx_re = 1'b1; tick(); cpu_rx_re = 1'b0;
            chk("R6 read clears full", cpu_rx_full, 0);
        end

        // R7: destination full holds the next word back
        wa = pat(7); wb = pat(8);
        cpu_send(wa); tick();
        cpu_send(wb);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7 source waits", cpu_tx_empty, 0);
            host_bytes("R7 dest kept", wa);
        end
        host_take_low();
        chk("R7 released", host_rx_full, 0);
        tick();
        chk("R7 moved after release", host_rx_full, 1);
        chk("R7 tx_empty", cpu_tx_empty, 1);
        host_bytes("R7 new word", wb);
        host_take_low();

        // R11: write on the same edge as a move
        wa = pat(31); wb = pat(32);
        cpu_send(wa);
        cpu_send(wb);
        chk("R11 host full", host_rx_full, 1);
        chk("R11 empty stays 0", cpu_tx_empty, 0);
        host_bytes("R11 old word moved", wa);
        host_take_low();
        tick();
        chk("R11 second move", host_rx_full, 1);
        host_bytes("R11 new word moved", wb);
        host_take_low();

        // R8: interrupt requests
        pulse_ctl(5'b00010);
        chk("R8 irq_tx on", irq_tx, 1);
        pulse_ctl(5'b00000);
        chk("R8 irq_tx off", irq_tx, 0);
        pulse_ctl(5'b00001);
        chk("R8 irq_rx idle", irq_rx, 0);
        host_send(pat(50)); tick();
        chk("R8 irq_rx on", irq_rx, 1);
        chk("R8 irq_tx masked", irq_tx, 0);
        cpu_rx_re = 1'b1; tick(); cpu_rx_re = 1'b0;
        chk("R8 irq_rx off", irq_rx, 0);

        // R9 / R10: reset types
        wa = pat(61); wb = pat(62);
        host_send(wa); tick();
        cpu_send(wb); tick();
        pulse_ctl(5'h1F);
        for (int r = 0; r < 4; r++) begin
            if (r == 3) pulse_ctl(5'h1F);
            ind_rst  = (r == 0);
            stop_rst = (r == 1);
            sw_rst   = (r == 2);
            rst      = (r == 3);
            tick();
            ind_rst = 1'b0; stop_rst = 1'b0; sw_rst = 1'b0; rst = 1'b0;
            chk("R10 ctl after reset", cpu_ctl_rdata, (r < 2) ? 5'h1F : 5'h00);
            chk("R10 flags idle", {cpu_rx_full, host_rx_full, cpu_tx_empty, host_tx_empty}, 4'b0011);
            chk("R9 cpu word kept", cpu_rx_rdata, wa);
            host_bytes("R9 host bytes kept", wb);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule